// File: doc/BRIEF.md
# Timestamped Sample Packer with Zero Suppression

This block sits between a flash ADC and a capture FIFO. It takes one 8-bit sample on every sample clock. It collects six consecutive samples into one 64-bit word, together with a 16-bit timestamp. The timestamp comes from a free-running counter on the same clock, and the packed word goes out through a write-enable and data pair. Output words therefore appear at one sixth of the sample rate.

Zero suppression keeps memory traffic low. When it is on, a group is written only if the front-end comparator flagged at least one of its six samples. When it is off, every group is written. A run-enable qualifier gates all writes without stopping the timestamp counter. A full flag from the FIFO drops the word at hand. A write pointer counts the words written and gives the address of the word currently being written.

Group boundaries depend only on the clock count since reset. A group is made of the samples taken on clocks 6g to 6g+5 after reset release. A pulse about 36 ns long at the nominal 500 MHz sample rate yields three words.

Top module: `adc_word_packer`

## Requirements
- R1: While reset is asserted and before the first group completes, `wr_en_o` is 0, `wr_ptr_o` is 0 and `wr_data_o` is 0.
- R2: In a packed word, the sample taken k clocks into the group (k = 0..5) occupies bits [8k+7:8k] and the timestamp occupies bits [63:48].
- R3: The timestamp counter is 0 on the first clock after reset release and adds one on every clock, modulo 2^16. A word's timestamp is the counter value on the clock of its first sample.
- R4: `wr_en_o` can rise only in the cycle after the sixth sample of a group is taken, and it stays high for exactly one cycle.
- R5: With suppression enabled (`suppress_en_i`=1), a group is written if and only if `above_thr_i` was 1 on at least one of its six sample clocks, whichever position that is.
- R6: With suppression disabled, every group is written regardless of `above_thr_i`.
- R7: A group whose last sample clock sees `run_en_i`=0 is not written. The timestamp counter keeps advancing while runs are disabled.
- R8: A group whose last sample clock sees `fifo_full_i`=1 is not written, and `wr_ptr_o` is unchanged.
- R9: `wr_ptr_o` equals the number of words written since reset, counted before the current write. It increases by exactly one in the cycle after each write.
- R10: Groups start every six clocks from reset release, whatever the comparator does. The comparator history of one group does not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 8 | ADC sample, one per clock |
| above_thr_i | input | 1 | Comparator: signal above threshold this clock |
| suppress_en_i | input | 1 | 1 = write only groups with a comparator hit |
| run_en_i | input | 1 | Run-control write qualifier |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept a word |
| wr_en_o | output | 1 | FIFO write strobe, one cycle per written word |
| wr_data_o | output | 64 | Packed word: timestamp in [63:48], six samples below |
| wr_ptr_o | output | 16 | Memory write pointer (address of the current write) |

## Verification
The assertions assume that `run_en_i`, `fifo_full_i` and `suppress_en_i` are synchronous to the sample clock and settle between edges. They also assume that reset is released cleanly, so the phase counter starts at zero. The bench changes every input only on falling edges. It holds the qualifiers constant for the whole of a group, so the sample-5 decision the assertions watch is unambiguous. Comparator patterns put a single hit at the first or last position, or none at all, to test how hits accumulate and clear at group boundaries.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
   // status of the group that completes on the current clock
   typedef struct packed {
      logic done;
      logic hit;
   } grp_stat_t;
endpackage

// File: rtl/adc_pack_timebase.sv
module adc_pack_timebase #(
   parameter int TIME_W  = 16,
   parameter int SAMPLES = 6,
   localparam int PH_W   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] tstamp_o,
   output logic [PH_W-1:0]   phase_o,
   output logic              first_o,
   output logic              last_o
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SAMPLES - 1);

   generate
      if (TIME_W < 2) begin : g_bad_time
         $error("TIME_W must be at least 2");
      end
      if (SAMPLES < 2) begin : g_bad_samples
         $error("SAMPLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tstamp_o <= '0;
         phase_o  <= '0;
      end else begin
         tstamp_o <= tstamp_o + 1'b1;
         phase_o  <= (phase_o == PH_LAST) ? '0 : phase_o + 1'b1;
      end
   end

   assign first_o = (phase_o == '0);
   assign last_o  = (phase_o == PH_LAST);

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tstamp_o == $past(tstamp_o) + 1'b1); // R3
   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> first_o); // R10
endmodule

// File: rtl/adc_pack_assembler.sv
module adc_pack_assembler
   import adc_pack_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int SAMPLES  = 6,
   parameter int TIME_W   = 16,
   localparam int PH_W    = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
   localparam int WORD_W  = SAMPLES * SAMPLE_W + TIME_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                above_thr_i,
   input  logic [TIME_W-1:0]   tstamp_i,
   input  logic [PH_W-1:0]     phase_i,
   input  logic                first_i,
   input  logic                last_i,
   output grp_stat_t           stat_o,
   output logic [WORD_W-1:0]   word_o
);
   logic [SAMPLE_W-1:0] slot_q [SAMPLES-1];
   logic [TIME_W-1:0]   t0_q;
   logic                hit_q;
   logic [WORD_W-1:0]   word_d;

   // one holding register per sample position except the last
   generate
      for (genvar k = 0; k < SAMPLES - 1; k++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)                     slot_q[k] <= '0;
            else if (phase_i == PH_W'(k))   slot_q[k] <= sample_i;
         end
         assign word_d[k*SAMPLE_W +: SAMPLE_W] = slot_q[k];
      end
   endgenerate

   assign word_d[(SAMPLES-1)*SAMPLE_W +: SAMPLE_W] = sample_i;
   assign word_d[WORD_W-1 -: TIME_W]               = t0_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t0_q   <= '0;
         hit_q  <= 1'b0;
         word_o <= '0;
      end else begin
         if (first_i) t0_q <= tstamp_i;
         hit_q <= first_i ? above_thr_i : (hit_q | above_thr_i);
         if (last_i) word_o <= word_d;
      end
   end

   assign stat_o.done = last_i;
   assign stat_o.hit  = hit_q | above_thr_i;

   AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (first_i && !above_thr_i) |=> !hit_q); // R10
endmodule

// File: rtl/adc_pack_wrgate.sv
module adc_pack_wrgate
   import adc_pack_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  grp_stat_t        stat_i,
   input  logic             suppress_en_i,
   input  logic             run_en_i,
   input  logic             fifo_full_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] ptr_o
);
   generate
      if (PTR_W < 1) begin : g_bad_ptr
         $error("PTR_W must be positive");
      end
   endgenerate

   logic keep;
   assign keep = !suppress_en_i || stat_i.hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en_o <= 1'b0;
         ptr_o   <= '0;
      end else begin
         wr_en_o <= stat_i.done && run_en_i && !fifo_full_i && keep;
         if (wr_en_o) ptr_o <= ptr_o + 1'b1;
      end
   end

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full_i |=> !wr_en_o); // R8
   AST_RUN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en_i |=> !wr_en_o); // R7
   AST_SUPPRESS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (suppress_en_i && !stat_i.hit) |=> !wr_en_o); // R5
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> ptr_o == $past(ptr_o) + 1'b1); // R9
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_o |=> $stable(ptr_o)); // R9
endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer
   import adc_pack_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int SAMPLES  = 6,
   parameter int TIME_W   = 16,
   parameter int PTR_W    = 16,
   localparam int PH_W    = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
   localparam int WORD_W  = SAMPLES * SAMPLE_W + TIME_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                above_thr_i,
   input  logic                suppress_en_i,
   input  logic                run_en_i,
   input  logic                fifo_full_i,
   output logic                wr_en_o,
   output logic [WORD_W-1:0]   wr_data_o,
   output logic [PTR_W-1:0]    wr_ptr_o
);
   logic [TIME_W-1:0] tstamp;
   logic [PH_W-1:0]   phase;
   logic              ph_first, ph_last;
   grp_stat_t         stat;

   adc_pack_timebase #(.TIME_W(TIME_W), .SAMPLES(SAMPLES)) u_timebase (
      .clk(clk), .rst_n(rst_n), .tstamp_o(tstamp), .phase_o(phase),
      .first_o(ph_first), .last_o(ph_last));

   adc_pack_assembler #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .TIME_W(TIME_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .above_thr_i(above_thr_i),
      .tstamp_i(tstamp), .phase_i(phase), .first_i(ph_first), .last_i(ph_last),
      .stat_o(stat), .word_o(wr_data_o));

   adc_pack_wrgate #(.PTR_W(PTR_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .stat_i(stat), .suppress_en_i(suppress_en_i),
      .run_en_i(run_en_i), .fifo_full_i(fifo_full_i),
      .wr_en_o(wr_en_o), .ptr_o(wr_ptr_o));

   AST_SINGLE_CYCLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o); // R4
   AST_WRITE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_last |=> !wr_en_o); // R4
endmodule

// File: tb/adc_word_packer_bench.sv
module adc_word_packer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sample_i = '0;
   logic        above_thr_i = 1'b0, suppress_en_i = 1'b0, run_en_i = 1'b1, fifo_full_i = 1'b0;
   logic        wr_en_o;
   logic [63:0] wr_data_o;
   logic [15:0] wr_ptr_o;

   int tests = 0, fails = 0;
   int grp = 0;          // groups started since reset release
   int exp_ptr = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adc_word_packer u_adc_word_packer (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .above_thr_i(above_thr_i),
      .suppress_en_i(suppress_en_i), .run_en_i(run_en_i), .fifo_full_i(fifo_full_i),
      .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_ptr_o(wr_ptr_o));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // entered and left on a falling edge
   task automatic run_group(input logic [47:0] smp, input logic [5:0] thr,
                            input logic supp, input logic run, input logic full,
                            input string tag);
      logic [15:0] t0;
      logic        exp_wr;
      logic        early = 1'b0;
      t0 = 16'(grp * 6);
      suppress_en_i = supp; run_en_i = run; fifo_full_i = full;
      for (int k = 0; k < 6; k++) begin
         sample_i    = smp[8*k +: 8];
         above_thr_i = thr[k];
         @(negedge clk);
         if (k < 5 && wr_en_o) early = 1'b1;
      end
      grp++;
      exp_wr = run && !full && (!supp || (|thr));
      check({tag, " R4 no mid-group strobe"}, 64'(early), 64'(0));
      check({tag, " write decision R5/R6/R7/R8"}, 64'(wr_en_o), 64'(exp_wr));
      check({tag, " R9 pointer"}, 64'(wr_ptr_o), 64'(16'(exp_ptr)));
      if (exp_wr) begin
         check({tag, " R2/R3 word"}, wr_data_o, {t0, smp});
         exp_ptr++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 wr_en in reset", 64'(wr_en_o), 64'(0));
      check("R1 ptr in reset", 64'(wr_ptr_o), 64'(0));
      check("R1 data in reset", wr_data_o, 64'(0));
      rst_n = 1'b1;   // next rising edge is the first clock of group 0
   endtask

   task automatic t_unsuppressed();
      run_group(48'h665544332211, 6'b000000, 1'b0, 1'b1, 1'b0, "R6 group0");
      run_group(48'hF0E0D0C0B0A0, 6'b000000, 1'b0, 1'b1, 1'b0, "R6 group1");
   endtask

   task automatic t_suppressed();
      run_group(48'h010203040506, 6'b000000, 1'b1, 1'b1, 1'b0, "R5 quiet");
      run_group(48'h1112131415FF, 6'b100000, 1'b1, 1'b1, 1'b0, "R5 last hit");
      run_group(48'h7F0000000081, 6'b000001, 1'b1, 1'b1, 1'b0, "R5 first hit");
      run_group(48'h222222222222, 6'b000000, 1'b1, 1'b1, 1'b0, "R10 hit clears");
   endtask

   task automatic t_run_full();
      run_group(48'hAAAAAAAAAAAA, 6'b111111, 1'b0, 1'b0, 1'b0, "R7 run off");
      run_group(48'h0123456789AB, 6'b000000, 1'b0, 1'b1, 1'b0, "R7 time advanced");
      run_group(48'hBBBBBBBBBBBB, 6'b111111, 1'b0, 1'b1, 1'b1, "R8 full");
      run_group(48'hCAFEBABE1234, 6'b000000, 1'b0, 1'b1, 1'b0, "R8 resume");
   endtask

   task automatic t_wrap();
      // quiet groups up to the one starting at 65532, then two written ones
      while (grp < 10922)
         run_group(48'h0, 6'b000000, 1'b1, 1'b1, 1'b0, "R5 filler");
      run_group(48'h5A5A5A5A5A5A, 6'b000000, 1'b0, 1'b1, 1'b0, "R3 pre-wrap");
      run_group(48'hA5A5A5A5A5A5, 6'b000000, 1'b0, 1'b1, 1'b0, "R3 wrapped");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_unsuppressed();
      t_suppressed();
      t_run_full();
      t_wrap();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule